// File: doc/BRIEF.md
# Pattern Sequencer with Pad Direction Control

The block stores a table of pattern words and plays a programmable slice of it back, one word per clock. Software, or a surrounding controller, loads the table through a plain address/data/write-enable port while the sequencer is idle. It then gives a first and a last address and pulses `start`. Every word from the first address up to and including the last address is presented in ascending order. `busy` stays high until the final word has had its cycle on the outputs.

Each pattern word has two fields. Bits 31..0 drive 32 bidirectional pads. A per-bit direction word `ioctrl` chooses, bit by bit, whether a pad is driven or read. Pads 7, 8, 11, 14 and 20 can be taken over by external detector state machines: while any of them reports running, those pads are driven from `sm_val`, whatever the pattern and `ioctrl` say. Bits 47..32 drive 16 output-only pads, and `ioctrl` has no effect on them. The block forms a 48-bit sample word from the 16-bit output field and the 32 pad levels. It also raises two independent one-clock strobes, one for sampling and one for packet sending, each on the rising edge of an output-field bit chosen by a 4-bit index.

The sequencer is a three-state machine. IDLE waits for `start`. The transition IDLE→RUN latches both addresses. RUN fetches one word per clock. The transition RUN→LAST is taken when the word just fetched is at or beyond the stop address. LAST holds `busy` for the cycle in which the final word is shown, and LAST→IDLE follows unconditionally. The last word shown stays on the outputs after playback ends.

Top module: `pattern_player`

## Requirements
- R1: Words written while idle are played back in ascending address order from the start address through the stop address, both included, with one word shown per clock. Each shown word is marked by `play_vld`.
- R2: When the stop address is below the start address, only the word at the start address is played.
- R3: While `busy` is high, writes are discarded and further `start` pulses are ignored. The run in progress continues unchanged.
- R4: `busy` rises on the clock after `start` and is high on every cycle that `play_vld` is high. `busy` falls together with `play_vld` one clock after the final word appears. The last word then stays on the outputs.
- R5: When no override is active, `dio_oe` equals `ioctrl` and `dio_o` equals bits 31..0 of the current word. Sample bit i is `dio_o[i]` where `dio_oe[i]` is 1 and `dio_i[i]` where it is 0.
- R6: While any bit of `sm_run` is 1, pads 7, 8, 11, 14 and 20 are driven (oe = 1) with the matching bits of `sm_val`. All other pads follow R5.
- R7: `do_o` equals bits 47..32 of the current word whatever the value of `ioctrl`.
- R8: `sample` is {`do_o`, pad levels}: bits 47..32 are the output field and bits 31..0 are the pad levels of R5/R6.
- R9: `smp_stb` is high for exactly the clock in which `do_o[smp_sel]` has just risen from 0 to 1.
- R10: `pkt_stb` behaves as R9 for `do_o[pkt_sel]`, independently of `smp_sel`.
- R11: After reset, `busy`, `play_vld`, `do_o`, `dio_o`, `smp_stb` and `pkt_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe (ignored while busy) |
| wr_addr | input | ADDR_W | Table write address |
| wr_data | input | 48 | Table write word |
| start | input | 1 | One-clock playback start pulse |
| start_addr | input | ADDR_W | First address played |
| stop_addr | input | ADDR_W | Last address played (included) |
| ioctrl | input | 32 | Per-pad direction, 1 = drive |
| sm_run | input | SM_N | Running flags of the external state machines |
| sm_val | input | 32 | Override values for pads 7, 8, 11, 14, 20 |
| dio_i | input | 32 | Pad input levels |
| dio_o | output | 32 | Pad output values |
| dio_oe | output | 32 | Pad output enables |
| do_o | output | 16 | Output-only pad field |
| busy | output | 1 | Playback in progress |
| play_vld | output | 1 | A freshly played word is on the outputs |
| sample | output | 48 | Digital sample word |
| smp_sel | input | 4 | Output-field bit used as sample trigger |
| pkt_sel | input | 4 | Output-field bit used as packet trigger |
| smp_stb | output | 1 | Sample trigger strobe |
| pkt_stb | output | 1 | Packet trigger strobe |

## Verification
The bench plays a single-word range and a reversed range. A design that treats the stop address as exclusive loses the final word. A design that wraps on a reversed range runs through the whole table. During a run, the bench overwrites a word that the run is about to fetch and pulses `start` again. A sequencer that does not lock out these inputs either plays the new word or restarts, and an unexpected or missing word then shows up in the scoreboard. Pad checks mix input and output directions and switch the override on with `ioctrl` cleared, which exposes an override that fails to force the enable or that leaks onto other pads. The strobe checks follow edges across run boundaries, where the held last word of one run is the "previous" value for the first word of the next.

// File: rtl/pattern_player_pkg.sv
package pattern_player_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } play_state_t;

endpackage

// File: rtl/pp_mem.sv
module pp_mem #(
    parameter int WORD_W = 48,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // read register doubles as the pattern output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/pp_seq.sv
module pp_seq
    import pattern_player_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] stop_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              vld
);
    play_state_t       state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [ADDR_W-1:0] stop_q, stop_d;
    logic              vld_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            stop_q  <= '0;
            vld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            stop_q  <= stop_d;
            vld_q   <= rd_en;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        stop_d  = stop_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    pc_d    = start_addr;
                    stop_d  = stop_addr;
                end
            end
            ST_RUN: begin
                // reaching or passing the stop address ends the run,
                // so a reversed range plays the start word only
                if (pc_q >= stop_q) begin
                    state_d = ST_LAST;
                end else begin
                    pc_d = pc_q + 1'b1;
                end
            end
            ST_LAST: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        rd_en   = (state_q == ST_RUN);
        rd_addr = pc_q;
        busy    = (state_q != ST_IDLE);
        vld     = vld_q;
    end
endmodule

// File: rtl/pp_io.sv
module pp_io #(
    parameter int          PIN_W    = 32,
    parameter int          DO_W     = 16,
    parameter int          SEL_W    = 4,
    parameter int          SM_N     = 2,
    parameter logic [31:0] OVR_MASK = 32'h0010_4980
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIN_W-1:0]      pat_pins,
    input  logic [DO_W-1:0]       pat_do,
    input  logic [PIN_W-1:0]      ioctrl,
    input  logic [SM_N-1:0]       sm_run,
    input  logic [PIN_W-1:0]      sm_val,
    input  logic [PIN_W-1:0]      dio_i,
    output logic [PIN_W-1:0]      dio_o,
    output logic [PIN_W-1:0]      dio_oe,
    output logic [DO_W-1:0]       do_o,
    output logic [PIN_W+DO_W-1:0] sample,
    input  logic [SEL_W-1:0]      smp_sel,
    input  logic [SEL_W-1:0]      pkt_sel,
    output logic                  smp_stb,
    output logic                  pkt_stb
);
    localparam logic [PIN_W-1:0] MASK = PIN_W'(OVR_MASK);

    logic             ovr_on;
    logic [PIN_W-1:0] pin_lvl;
    logic [DO_W-1:0]  do_prev;
    logic [DO_W-1:0]  do_rise;

    assign ovr_on = |sm_run;
    assign dio_o  = ovr_on ? ((pat_pins & ~MASK) | (sm_val & MASK)) : pat_pins;
    assign dio_oe = ovr_on ? (ioctrl | MASK) : ioctrl;
    assign do_o   = pat_do;

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        assign pin_lvl[i] = dio_oe[i] ? dio_o[i] : dio_i[i];
    end

    assign sample = {pat_do, pin_lvl};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            do_prev <= '0;
        end else begin
            do_prev <= pat_do;
        end
    end

    assign do_rise = pat_do & ~do_prev;
    assign smp_stb = do_rise[smp_sel];
    assign pkt_stb = do_rise[pkt_sel];
endmodule

// File: rtl/pattern_player.sv
module pattern_player #(
    parameter int          ADDR_W   = 10,
    parameter int          PIN_W    = 32,
    parameter int          DO_W     = 16,
    parameter int          SM_N     = 2,
    parameter logic [31:0] OVR_MASK = 32'h0010_4980,
    localparam int         WORD_W   = PIN_W + DO_W,
    localparam int         SEL_W    = $clog2(DO_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] stop_addr,
    input  logic [PIN_W-1:0]  ioctrl,
    input  logic [SM_N-1:0]   sm_run,
    input  logic [PIN_W-1:0]  sm_val,
    input  logic [PIN_W-1:0]  dio_i,
    output logic [PIN_W-1:0]  dio_o,
    output logic [PIN_W-1:0]  dio_oe,
    output logic [DO_W-1:0]   do_o,
    output logic              busy,
    output logic              play_vld,
    output logic [WORD_W-1:0] sample,
    input  logic [SEL_W-1:0]  smp_sel,
    input  logic [SEL_W-1:0]  pkt_sel,
    output logic              smp_stb,
    output logic              pkt_stb
);
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] pat_q;

    pp_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .stop_addr  (stop_addr),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .vld        (play_vld)
    );

    pp_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en & ~busy),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (pat_q)
    );

    pp_io #(
        .PIN_W    (PIN_W),
        .DO_W     (DO_W),
        .SEL_W    (SEL_W),
        .SM_N     (SM_N),
        .OVR_MASK (OVR_MASK)
    ) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .pat_pins (pat_q[PIN_W-1:0]),
        .pat_do   (pat_q[WORD_W-1:PIN_W]),
        .ioctrl   (ioctrl),
        .sm_run   (sm_run),
        .sm_val   (sm_val),
        .dio_i    (dio_i),
        .dio_o    (dio_o),
        .dio_oe   (dio_oe),
        .do_o     (do_o),
        .sample   (sample),
        .smp_sel  (smp_sel),
        .pkt_sel  (pkt_sel),
        .smp_stb  (smp_stb),
        .pkt_stb  (pkt_stb)
    );
endmodule

// File: rtl/pattern_player_chk.sv
module pattern_player_chk #(
    parameter int          PIN_W    = 32,
    parameter int          DO_W     = 16,
    parameter int          SEL_W    = 4,
    parameter int          SM_N     = 2,
    parameter logic [31:0] OVR_MASK = 32'h0010_4980
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  play_vld,
    input logic [SM_N-1:0]       sm_run,
    input logic [PIN_W-1:0]      ioctrl,
    input logic [PIN_W-1:0]      sm_val,
    input logic [PIN_W-1:0]      dio_o,
    input logic [PIN_W-1:0]      dio_oe,
    input logic [DO_W-1:0]       do_o,
    input logic [PIN_W+DO_W-1:0] sample,
    input logic [SEL_W-1:0]      smp_sel,
    input logic [SEL_W-1:0]      pkt_sel,
    input logic                  smp_stb,
    input logic                  pkt_stb
);
    localparam logic [PIN_W-1:0] MASK = PIN_W'(OVR_MASK);

    assert_start_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_vld_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        play_vld |-> busy);

    assert_busy_ends_after_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(play_vld));

    assert_dir_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|sm_run) |-> (dio_oe == ioctrl));

    assert_sample_driven_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sample[PIN_W-1:0] ^ dio_o) & dio_oe) == '0);

    assert_override_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|sm_run) |-> (((dio_oe & MASK) == MASK) && ((dio_o & MASK) == (sm_val & MASK))));

    assert_sample_high_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample[PIN_W+DO_W-1:PIN_W] == do_o);

    assert_smp_one_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (!smp_stb || (smp_sel != $past(smp_sel))));

    assert_pkt_one_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_stb |=> (!pkt_stb || (pkt_sel != $past(pkt_sel))));
endmodule

bind pattern_player pattern_player_chk #(
    .PIN_W    (PIN_W),
    .DO_W     (DO_W),
    .SEL_W    (SEL_W),
    .SM_N     (SM_N),
    .OVR_MASK (OVR_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .play_vld (play_vld),
    .sm_run   (sm_run),
    .ioctrl   (ioctrl),
    .sm_val   (sm_val),
    .dio_o    (dio_o),
    .dio_oe   (dio_oe),
    .do_o     (do_o),
    .sample   (sample),
    .smp_sel  (smp_sel),
    .pkt_sel  (pkt_sel),
    .smp_stb  (smp_stb),
    .pkt_stb  (pkt_stb)
);

// File: tb/test_pattern_player.sv
module test_pattern_player;
    localparam int          ADDR_W = 10;
    localparam int          PIN_W  = 32;
    localparam int          DO_W   = 16;
    localparam int          WORD_W = 48;
    localparam int          SM_N   = 2;
    localparam logic [31:0] OVR    = 32'h0010_4980; // pads 7, 8, 11, 14, 20

    logic              clk;
    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              start;
    logic [ADDR_W-1:0] start_addr, stop_addr;
    logic [PIN_W-1:0]  ioctrl, sm_val, dio_i, dio_o, dio_oe;
    logic [SM_N-1:0]   sm_run;
    logic [DO_W-1:0]   do_o;
    logic              busy, play_vld, smp_stb, pkt_stb;
    logic [WORD_W-1:0] sample;
    logic [3:0]        smp_sel, pkt_sel;

    pattern_player i_pattern_player (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .start_addr(start_addr), .stop_addr(stop_addr), .ioctrl(ioctrl),
        .sm_run(sm_run), .sm_val(sm_val), .dio_i(dio_i), .dio_o(dio_o), .dio_oe(dio_oe),
        .do_o(do_o), .busy(busy), .play_vld(play_vld), .sample(sample),
        .smp_sel(smp_sel), .pkt_sel(pkt_sel), .smp_stb(smp_stb), .pkt_stb(pkt_stb)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int                n_run  = 0;
    int                n_fail = 0;
    int                n_smp  = 0;
    int                n_pkt  = 0;
    bit                done   = 0;
    bit                last_v = 0;
    logic [WORD_W-1:0] expq [$];
    logic [WORD_W-1:0] shadow [64];
    logic [DO_W-1:0]   prev_do = '0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mkword(input int i);
        logic [DO_W-1:0]  d;
        logic [PIN_W-1:0] p;
        d = DO_W'(i * 16'h2A5B) ^ DO_W'(i << 3);
        p = PIN_W'(i * 32'h9E37_79B9);
        return {d, p};
    endfunction

    // monitor: pops scoreboard entries as played words appear
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && !done) begin
                logic [WORD_W-1:0] w;
                logic [DO_W-1:0]   cur;
                logic [PIN_W-1:0]  eoe, eout, elvl;
                logic              ovr;
                ovr = |sm_run;
                cur = prev_do;
                w   = {prev_do, dio_o};
                if (play_vld) begin
                    chk("R4", "busy while word shown", 64'(busy), 64'd1);
                    if (expq.size() == 0) begin
                        n_run++;
                        n_fail++;
                        $display("FAIL R1 unexpected word actual=%h expected=none", {do_o, dio_o});
                    end else begin
                        w   = expq.pop_front();
                        cur = w[WORD_W-1:PIN_W];
                        eoe  = ovr ? (ioctrl | OVR) : ioctrl;
                        eout = ovr ? ((w[PIN_W-1:0] & ~OVR) | (sm_val & OVR)) : w[PIN_W-1:0];
                        elvl = (eoe & eout) | (~eoe & dio_i);
                        chk("R7", "output field", 64'(do_o), 64'(cur));
                        chk(ovr ? "R6" : "R5", "pad enable", 64'(dio_oe), 64'(eoe));
                        chk(ovr ? "R6" : "R5", "pad value", 64'(dio_o), 64'(eout));
                        chk("R8", "sample word", 64'(sample), 64'({cur, elvl}));
                    end
                end else begin
                    chk("R4", "held output field", 64'(do_o), 64'(prev_do));
                    if (last_v && expq.size() == 0)
                        chk("R4", "busy after final word", 64'(busy), 64'd0);
                end
                chk("R9", "sample strobe", 64'(smp_stb), 64'(cur[smp_sel] & ~prev_do[smp_sel]));
                chk("R10", "packet strobe", 64'(pkt_stb), 64'(cur[pkt_sel] & ~prev_do[pkt_sel]));
                if (cur[smp_sel] & ~prev_do[smp_sel]) n_smp++;
                if (cur[pkt_sel] & ~prev_do[pkt_sel]) n_pkt++;
                prev_do = cur;
                last_v  = play_vld;
            end
        end
    end

    task automatic wr(input int a, input logic [WORD_W-1:0] d);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse(input int s, input int e);
        start_addr = ADDR_W'(s);
        stop_addr  = ADDR_W'(e);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic begin_run(input int s, input int e);
        if (e < s) expq.push_back(shadow[s]);
        else for (int a = s; a <= e; a++) expq.push_back(shadow[a]);
        pulse(s, e);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1", "scoreboard drained", 64'(expq.size()), 64'd0);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; start = 0;
        start_addr = '0; stop_addr = '0; ioctrl = '1; sm_run = '0;
        sm_val = '0; dio_i = '0; smp_sel = 4'd3; pkt_sel = 4'd9;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "busy", 64'(busy), 64'd0);
        chk("R11", "play_vld", 64'(play_vld), 64'd0);
        chk("R11", "do_o", 64'(do_o), 64'd0);
        chk("R11", "dio_o", 64'(dio_o), 64'd0);
        chk("R11", "strobes", 64'({smp_stb, pkt_stb}), 64'd0);

        for (int a = 0; a < 40; a++) begin
            shadow[a] = mkword(a + 1);
            wr(a, shadow[a]);
        end

        // R1 inclusive range, R4 timing via monitor
        begin_run(2, 9);
        @(negedge clk);
        chk("R4", "busy after start", 64'(busy), 64'd1);
        wait_idle();
        chk("R4", "last word held", 64'(do_o), 64'(shadow[9][WORD_W-1:PIN_W]));

        // single word and R2 reversed range
        begin_run(5, 5);
        wait_idle();
        begin_run(12, 7);
        wait_idle();
        chk("R2", "reversed range holds start word", 64'(do_o), 64'(shadow[12][WORD_W-1:PIN_W]));

        // R3 write and restart during a run are ignored
        begin_run(0, 20);
        repeat (3) @(negedge clk);
        wr(10, 48'hDEAD_BEEF_F00D);
        pulse(30, 35);
        wait_idle();
        chk("R3", "no restart, busy low", 64'(busy), 64'd0);
        begin_run(8, 12);
        wait_idle();

        // R5 mixed directions, R7 field unaffected
        ioctrl = 32'h0F0F_00FF;
        dio_i  = 32'hA5A5_5A5A;
        smp_sel = 4'd0; pkt_sel = 4'd14;
        begin_run(13, 24);
        wait_idle();

        // R6 override with all pads set as inputs
        ioctrl = '0;
        sm_val = 32'hFFFF_FFFF;
        sm_run = 2'b10;
        begin_run(3, 8);
        wait_idle();
        sm_val = 32'h0000_4100;
        sm_run = 2'b01;
        ioctrl = 32'hFFFF_0000;
        smp_sel = 4'd15; pkt_sel = 4'd7;
        begin_run(25, 39);
        wait_idle();
        sm_run = '0;
        begin_run(0, 39);
        wait_idle();

        chk("R9", "sample strobes seen", 64'(n_smp > 0), 64'd1);
        chk("R10", "packet strobes seen", 64'(n_pkt > 0), 64'd1);

        done = 1;
        report();
        $finish;
    end
endmodule